// File: doc/BRIEF.md
# Reciprocal-Multiply Constant Divider

This block divides a 32-bit unsigned dividend by a divisor that stays fixed over many operations. It does not use an iterative divider. It multiplies the dividend by a precomputed magic number, keeps the upper half of the product, and applies a few shifts and adds. Software or a compiler computes the magic number and the shift counts once for each divisor and presents them with every operation. The block never derives them itself.

The divisor and its control values decide which path is taken, in this priority order:

1. A zero divisor is an error.
2. A divisor with any bit set above bit 31 gives a quotient of zero.
3. A divisor above 2^31 reduces to a single compare.
4. An exact power of two reduces to a right shift.
5. A magic number wider than 32 bits uses a subtract, halve, add and shift correction.
6. All other divisors use the plain path: an optional pre-shift, then the high-half multiply, then a post-shift.

The datapath is a three-register pipeline. It accepts one operation per clock and returns results in order.

Top module: `recip_divider`

## Requirements
- R1: A divisor of zero produces `div_err` high for one cycle in the result slot, with `q_valid` low. `q_valid` and `div_err` are never high together.
- R2: A divisor with any nonzero bit at position 32 or above yields a valid quotient of 0.
- R3: A divisor that fits in 32 bits and exceeds 2^31 yields a quotient of 1 when dividend >= divisor, and 0 otherwise.
- R4: A divisor equal to 2^`pow_exp` (with `pow_exp` < 32) yields `dividend >> pow_exp`. This path takes priority over the magic-number paths.
- R5: When `magic_wide` is 1, let t be bits [63:32] of dividend × `magic`. The quotient is `(((dividend - t) >> 1) + t) >> (post_sh - 1)`, and `pre_sh` is ignored. Given correct control values, this equals floor(dividend / divisor).
- R6: When `magic_wide` is 0, the quotient is bits [63:32] of `(dividend >> pre_sh)` × `magic`, shifted right by `post_sh`. Given correct control values, including a nonzero pre-shift for even divisors, this equals floor(dividend / divisor).
- R7: An operation presented with `in_valid` high in clock cycle c produces its result (`q_valid` or `div_err`) in cycle c+3. Back-to-back operations are accepted every cycle and return in order. No result appears without a matching input.
- R8: While `rst_n` is low, `q_valid` and `div_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| dividend | input | 32 | Unsigned dividend |
| divisor | input | DIVISOR_W (64) | Unsigned divisor |
| magic | input | 32 | Low 32 bits of the magic multiplier |
| magic_wide | input | 1 | Magic multiplier has a 33rd bit (selects the correction path) |
| post_sh | input | 6 | Right shift applied after the multiply |
| pre_sh | input | 6 | Right shift applied to the dividend before the multiply |
| pow_exp | input | 6 | Base-2 exponent for the power-of-two check |
| q_valid | output | 1 | Quotient valid |
| quotient | output | 32 | Unsigned quotient |
| div_err | output | 1 | Zero-divisor error for this result slot |

## Verification
The bench feeds every path with dividends of 0, all ones, divisor−1, divisor and random values, and compares each result against the true integer quotient.

The divisors cover these cases:
- Powers of two, including 1 and 2^31, where a wrong priority would send the operation to a magic path with bogus controls.
- Even divisors that need a pre-shift, where dropping it gives quotients off by a factor of two.
- Odd divisors such as 7, whose magic number is wide. A missing halve or a wrong `post_sh - 1` would overflow or double the result.
- Divisors just above 2^31, where a carry-compare error flips 0 and 1.
- Divisors with high bits set, and zero divisors.

Each result's arrival cycle is also checked, so a pipeline stage that is dropped or duplicated is caught.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned SH_W   = $clog2(DATA_W) + 1;
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned HALF_W = DATA_W / 2;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [SH_W-1:0]   shamt_t;

  typedef enum logic [2:0] {
    PATH_ERR  = 3'd0,
    PATH_ZERO = 3'd1,
    PATH_CMP  = 3'd2,
    PATH_POW2 = 3'd3,
    PATH_WIDE = 3'd4,
    PATH_NORM = 3'd5
  } path_e;

  // operation after path selection and pre-shift
  typedef struct packed {
    logic   vld;
    path_e  path;
    word_t  num;
    word_t  mul_a;
    word_t  magic;
    shamt_t sh;
    shamt_t pexp;
    logic   ge;
  } s1_t;

  // operation after the high-half multiply
  typedef struct packed {
    logic   vld;
    path_e  path;
    word_t  num;
    word_t  t_hi;
    shamt_t sh;
    shamt_t pexp;
    logic   ge;
  } s2_t;

  // logical right shift that returns zero once the count reaches the width
  function automatic word_t shr_sat(word_t v, shamt_t n);
    if (int'(n) >= DATA_W) return '0;
    return v >> n;
  endfunction

  // upper half of a full-width product, single multiplier
  function automatic word_t mul_high(word_t a, word_t b);
    logic [PROD_W-1:0] p;
    p = PROD_W'(a) * PROD_W'(b);
    return p[PROD_W-1:DATA_W];
  endfunction

  // upper half of the product built from four half-width partial products
  function automatic word_t mul_high_split(word_t a, word_t b);
    logic [PROD_W-1:0] ll, lh, hl, hh, p;
    ll = PROD_W'(a[HALF_W-1:0])      * PROD_W'(b[HALF_W-1:0]);
    lh = PROD_W'(a[HALF_W-1:0])      * PROD_W'(b[DATA_W-1:HALF_W]);
    hl = PROD_W'(a[DATA_W-1:HALF_W]) * PROD_W'(b[HALF_W-1:0]);
    hh = PROD_W'(a[DATA_W-1:HALF_W]) * PROD_W'(b[DATA_W-1:HALF_W]);
    p  = (hh << DATA_W) + (lh << HALF_W) + (hl << HALF_W) + ll;
    return p[PROD_W-1:DATA_W];
  endfunction

  // correction for a 33-bit magic: average dividend and t without overflow
  function automatic word_t wide_fixup(word_t n, word_t t, shamt_t sh);
    word_t  half;
    shamt_t fin;
    half = (n - t) >> 1;
    fin  = (sh == '0) ? '0 : shamt_t'(sh - 1'b1);
    return shr_sat(half + t, fin);
  endfunction

endpackage

// File: rtl/recip_div_front.sv
module recip_div_front
  import recip_div_pkg::*;
#(
  parameter int unsigned DIVISOR_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  word_t                dividend,
  input  logic [DIVISOR_W-1:0] divisor,
  input  word_t                magic,
  input  logic                 magic_wide,
  input  shamt_t               post_sh,
  input  shamt_t               pre_sh,
  input  shamt_t               pow_exp,
  output path_e                path_sel,
  output s1_t                  s1_q
);

  localparam word_t HALF_RANGE = word_t'(1) << (DATA_W - 1);

  word_t div_lo;
  logic  div_zero, div_hi, div_big, div_pow;
  s1_t   s1_d;

  assign div_lo   = divisor[DATA_W-1:0];
  assign div_zero = (divisor == '0);
  assign div_hi   = |divisor[DIVISOR_W-1:DATA_W];
  assign div_big  = div_lo > HALF_RANGE;
  assign div_pow  = (pow_exp < shamt_t'(DATA_W)) &&
                    (div_lo == (word_t'(1) << pow_exp));

  // priority of the special cases
  always_comb begin
    if (div_zero)        path_sel = PATH_ERR;
    else if (div_hi)     path_sel = PATH_ZERO;
    else if (div_big)    path_sel = PATH_CMP;
    else if (div_pow)    path_sel = PATH_POW2;
    else if (magic_wide) path_sel = PATH_WIDE;
    else                 path_sel = PATH_NORM;
  end

  always_comb begin
    s1_d.vld   = in_valid;
    s1_d.path  = path_sel;
    s1_d.num   = dividend;
    s1_d.mul_a = magic_wide ? dividend : shr_sat(dividend, pre_sh);
    s1_d.magic = magic;
    s1_d.sh    = post_sh;
    s1_d.pexp  = pow_exp;
    s1_d.ge    = (dividend >= div_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_q <= '0;
    else        s1_q <= s1_d;
  end

endmodule

// File: rtl/recip_div_mulhi.sv
module recip_div_mulhi
  import recip_div_pkg::*;
#(
  parameter int unsigned MUL_SPLIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  s1_t  s1_q,
  output s2_t  s2_q
);

  word_t t_d;
  s2_t   s2_d;

  generate
    if (MUL_SPLIT != 0) begin : g_split
      assign t_d = mul_high_split(s1_q.mul_a, s1_q.magic);
    end else begin : g_flat
      assign t_d = mul_high(s1_q.mul_a, s1_q.magic);
    end
  endgenerate

  always_comb begin
    s2_d.vld  = s1_q.vld;
    s2_d.path = s1_q.path;
    s2_d.num  = s1_q.num;
    s2_d.t_hi = t_d;
    s2_d.sh   = s1_q.sh;
    s2_d.pexp = s1_q.pexp;
    s2_d.ge   = s1_q.ge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_q <= '0;
    else        s2_q <= s2_d;
  end

endmodule

// File: rtl/recip_div_back.sv
module recip_div_back
  import recip_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  s2_t   s2_q,
  output logic  q_valid,
  output word_t quotient,
  output logic  div_err,
  output path_e res_path
);

  word_t q_next;

  always_comb begin
    case (s2_q.path)
      PATH_CMP:  q_next = word_t'(s2_q.ge);
      PATH_POW2: q_next = shr_sat(s2_q.num, s2_q.pexp);
      PATH_WIDE: q_next = wide_fixup(s2_q.num, s2_q.t_hi, s2_q.sh);
      PATH_NORM: q_next = shr_sat(s2_q.t_hi, s2_q.sh);
      default:   q_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      div_err  <= 1'b0;
      quotient <= '0;
      res_path <= PATH_ERR;
    end else begin
      q_valid  <= s2_q.vld && (s2_q.path != PATH_ERR);
      div_err  <= s2_q.vld && (s2_q.path == PATH_ERR);
      quotient <= q_next;
      res_path <= s2_q.path;
    end
  end

endmodule

// File: rtl/recip_divider.sv
module recip_divider
  import recip_div_pkg::*;
#(
  parameter int unsigned DIVISOR_W = 64,
  parameter int unsigned MUL_SPLIT = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    dividend,
  input  logic [DIVISOR_W-1:0] divisor,
  input  logic [DATA_W-1:0]    magic,
  input  logic                 magic_wide,
  input  logic [SH_W-1:0]      post_sh,
  input  logic [SH_W-1:0]      pre_sh,
  input  logic [SH_W-1:0]      pow_exp,
  output logic                 q_valid,
  output logic [DATA_W-1:0]    quotient,
  output logic                 div_err
);

  path_e path_sel;
  path_e res_path;
  s1_t   s1_q;
  s2_t   s2_q;

  recip_div_front #(.DIVISOR_W(DIVISOR_W)) u_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dividend(dividend),
    .divisor(divisor), .magic(magic), .magic_wide(magic_wide),
    .post_sh(post_sh), .pre_sh(pre_sh), .pow_exp(pow_exp),
    .path_sel(path_sel), .s1_q(s1_q)
  );

  recip_div_mulhi #(.MUL_SPLIT(MUL_SPLIT)) u_mul (
    .clk(clk), .rst_n(rst_n), .s1_q(s1_q), .s2_q(s2_q)
  );

  recip_div_back u_back (
    .clk(clk), .rst_n(rst_n), .s2_q(s2_q), .q_valid(q_valid),
    .quotient(quotient), .div_err(div_err), .res_path(res_path)
  );

endmodule

// File: rtl/recip_divider_chk.sv
module recip_divider_chk
  import recip_div_pkg::*;
#(
  parameter int unsigned DIVISOR_W = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [DATA_W-1:0]    dividend,
  input logic [DIVISOR_W-1:0] divisor,
  input logic [SH_W-1:0]      pow_exp,
  input logic                 q_valid,
  input logic [DATA_W-1:0]    quotient,
  input logic                 div_err,
  input path_e                res_path
);

  localparam word_t HALF_RANGE = word_t'(1) << (DATA_W - 1);

  logic hi_set;
  assign hi_set = |divisor[DIVISOR_W-1:DATA_W];

  // R1
  a_r1_zero_flags: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (divisor == '0) |-> ##3 (div_err && !q_valid));

  // R1
  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_valid && div_err));

  // R2
  a_r2_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hi_set |-> ##3 (q_valid && quotient == '0));

  // R3
  a_r3_cmp_bit: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !hi_set && (divisor[DATA_W-1:0] > HALF_RANGE) |-> ##3
      (q_valid && quotient == word_t'($past(dividend >= divisor[DATA_W-1:0], 3))));

  // R3
  a_r3_cmp_range: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && (res_path == PATH_CMP) |-> (quotient <= word_t'(1)));

  // R4
  a_r4_pow_shift: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !hi_set && (pow_exp < SH_W'(DATA_W)) &&
    (divisor[DATA_W-1:0] == (word_t'(1) << pow_exp)) |-> ##3
      (q_valid && quotient == ($past(dividend, 3) >> $past(pow_exp, 3))));

  // R7
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 (q_valid || div_err));

  // R7
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid || div_err) |-> $past(in_valid, 3));

endmodule

bind recip_divider recip_divider_chk #(.DIVISOR_W(DIVISOR_W)) u_chk (.*);

// File: tb/tb_recip_divider.sv
module tb_recip_divider;

  localparam int DW = 32;
  localparam int VW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] dividend = '0;
  logic [VW-1:0] divisor = '0;
  logic [DW-1:0] magic = '0;
  logic          magic_wide = 1'b0;
  logic [5:0]    post_sh = '0;
  logic [5:0]    pre_sh = '0;
  logic [5:0]    pow_exp = '0;
  logic          q_valid;
  logic [DW-1:0] quotient;
  logic          div_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    logic [DW-1:0] q;
    bit            err;
    int            issue;
    string         req;
  } item_t;
  item_t sb[$];

  recip_divider dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dividend(dividend),
    .divisor(divisor), .magic(magic), .magic_wide(magic_wide),
    .post_sh(post_sh), .pre_sh(pre_sh), .pow_exp(pow_exp),
    .q_valid(q_valid), .quotient(quotient), .div_err(div_err)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int fls(logic [31:0] x);
    for (int i = 31; i >= 0; i--) if (x[i]) return i + 1;
    return 0;
  endfunction

  function automatic int ctz(logic [31:0] x);
    for (int i = 0; i < 32; i++) if (x[i]) return i;
    return 32;
  endfunction

  // optimised invariant-divisor parameters at a given precision
  task automatic calc_magic(input logic [31:0] d, input int prec,
                            output logic [31:0] m, output int sh,
                            output int ex, output bit wide);
    logic [127:0] lo, hi;
    int l, ps;
    l  = fls(d - 32'd1);
    ps = l;
    lo = (128'd1 << (32 + l)) / d;
    hi = ((128'd1 << (32 + l)) + (128'd1 << (32 + l - prec))) / d;
    while (ps > 0 && (lo >> 1) < (hi >> 1)) begin
      lo = lo >> 1;
      hi = hi >> 1;
      ps--;
    end
    m    = hi[31:0];
    sh   = ps;
    ex   = l;
    wide = (hi > 128'hFFFF_FFFF);
  endtask

  task automatic send(input logic [31:0] n, input logic [63:0] d);
    item_t it;
    logic [31:0] m, d32;
    int sh, ex, ex2, pre;
    bit wide;
    m = '0; sh = 0; ex = 0; pre = 0; wide = 0;
    d32 = d[31:0];
    it.err = 0;
    if (d == 64'd0) begin
      it.err = 1; it.q = '0; it.req = "R1";
    end else if (d[63:32] != 0) begin
      it.q = '0; it.req = "R2";
    end else if (d32 > 32'h8000_0000) begin
      it.q = (n >= d32) ? 32'd1 : 32'd0; it.req = "R3";
    end else begin
      calc_magic(d32, 32, m, sh, ex, wide);
      if (wide && !d32[0]) begin
        pre = ctz(d32);
        calc_magic(d32 >> pre, 32 - pre, m, sh, ex2, wide);
      end
      it.q = n / d32;
      if (d32 == (32'd1 << ex)) it.req = "R4";
      else if (wide)            it.req = "R5";
      else                      it.req = "R6";
    end
    @(negedge clk);
    in_valid   = 1'b1;
    dividend   = n;
    divisor    = d;
    magic      = m;
    magic_wide = wide;
    post_sh    = 6'(sh);
    pre_sh     = 6'(pre);
    pow_exp    = 6'(ex);
    it.issue   = cyc;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      dividend = $urandom;
      divisor  = '0;
    end
  endtask

  // monitor: pop expected items as results emerge
  always @(negedge clk) begin
    if (rst_n && (q_valid || div_err)) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 unexpected result q=%0h err=%0b expected none", quotient, div_err);
      end else begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (div_err !== it.err || q_valid === it.err ||
            (!it.err && quotient !== it.q)) begin
          fails++;
          $display("FAIL %s q=%0h err=%0b valid=%0b expected q=%0h err=%0b",
                   it.req, quotient, div_err, q_valid, it.q, it.err);
        end
        checks++;
        if (cyc != it.issue + 3) begin
          fails++;
          $display("FAIL R7 latency actual=%0d expected=%0d", cyc - it.issue, 3);
        end
      end
    end
  end

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [63:0] dlist[$];
    logic [31:0] d32;
    repeat (3) @(negedge clk);
    checks++;
    if (q_valid !== 1'b0 || div_err !== 1'b0) begin
      fails++;
      $display("FAIL R8 q_valid=%0b div_err=%0b expected 0 0", q_valid, div_err);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // powers of two (R4)
    dlist = '{64'd1, 64'd2, 64'd8, 64'h1_0000, 64'h8000_0000};
    // even divisors needing pre-shift or not (R6, R5)
    dlist.push_back(64'd6);  dlist.push_back(64'd10); dlist.push_back(64'd12);
    dlist.push_back(64'd14); dlist.push_back(64'd100); dlist.push_back(64'd1000);
    dlist.push_back(64'(7 << 20)); dlist.push_back(64'h7FFF_FFFE);
    // odd divisors (R5, R6)
    dlist.push_back(64'd3); dlist.push_back(64'd5); dlist.push_back(64'd7);
    dlist.push_back(64'd641); dlist.push_back(64'd1000001); dlist.push_back(64'h7FFF_FFFF);
    // above half range (R3)
    dlist.push_back(64'h8000_0001); dlist.push_back(64'hC000_0000); dlist.push_back(64'hFFFF_FFFF);
    // too wide (R2) and zero (R1)
    dlist.push_back(64'h1_0000_0000); dlist.push_back(64'hFFFF_0000_0000_0003);
    dlist.push_back(64'd0);

    foreach (dlist[i]) begin
      d32 = dlist[i][31:0];
      send(32'd0, dlist[i]);
      send(32'hFFFF_FFFF, dlist[i]);
      send(d32 - 32'd1, dlist[i]);
      send(d32, dlist[i]);
      for (int k = 0; k < 4; k++) send($urandom, dlist[i]);
    end
    idle(3);

    // random divisors of varied magnitude
    for (int k = 0; k < 400; k++) begin
      logic [31:0] rd;
      rd = 32'($urandom) >> ($urandom % 32);
      send($urandom, {32'd0, rd});
    end
    for (int k = 0; k < 100; k++) send($urandom, {32'd0, 32'($urandom)});
    idle(6);

    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R7 outstanding=%0d expected 0", sb.size());
    end
    done = 1;
    finish_run();
  end

endmodule